// File: doc/BRIEF.md
# Priority interrupt arbiter with group sublevels

This block sits between a set of interrupt request nodes and the CPU. Each node raises a one-cycle request pulse that is latched into a sticky pending bit. Every cycle the block looks at all pending nodes whose control word enables them. It picks the one with the highest ordering key and presents that node's index and priority level to the CPU. The index lets a vectored CPU branch straight to the handler for that source.

The ordering key has two tiers. The 4-bit level comes first. Ties on level are broken by a 3-bit sublevel, formed from a one-bit group extension above a 2-bit group field. Nodes with equal keys fall back to index order. The winner is offered as a take request only when interrupts are globally enabled and the winner's level is strictly above the CPU's current level. A winner that does not meet this stays pending and keeps being shown.

An acknowledge strobe during an offer clears the pending bit of the node being offered. The block then re-arbitrates in the same clock edge.

A three-state machine tracks the outcome:
- `ST_IDLE`: no eligible node.
- `ST_HELD`: an eligible winner exists but is not allowed through.
- `ST_OFFER`: the winner is requested from the CPU.

The machine re-evaluates every edge, so any state can move to any other:
- `go_idle`: nothing is eligible.
- `go_held`: a winner exists but fails the level or enable test.
- `go_offer`: a winner passes both tests.

Top module: `irq_sublevel_arbiter`

## Requirements
- R1: After reset, and in the state with no eligible node, `take_req` is 0, `win_idx` is 0 and `win_lvl` is 0. Reset also empties all pending bits.
- R2: Each 9-bit control word is decoded as follows:
  - group field in bits [1:0];
  - level in bits [5:2];
  - node enable in bit 6;
  - bit 7 has no effect;
  - group extension in bit 8.
  A node whose enable is 0 never wins, but its pending bit is kept, so it wins once enabled.
- R3: `take_req` is 1 only when `gie` is 1 and the winner's level is strictly greater than `cpu_lvl`. An eligible winner at an equal or lower level, or with `gie` at 0, is still shown on `win_idx`/`win_lvl` with `take_req` at 0.
- R4: A request pulse sets its node's pending bit. The bit stays set until cleared by an acknowledge, however long the node is blocked.
- R5: A node whose level field is 0 never wins.
- R6: `ack` while `take_req` is 1 clears only the pending bit of the node on `win_idx`. `ack` while `take_req` is 0 has no effect.
- R7: Ordering between nodes is decided in two tiers:
  - a higher level wins;
  - at equal level, the higher sublevel {extension, group} wins, so the extension bit outranks both group bits.
- R8: Among nodes with identical level and sublevel, the lower index wins.
- R9: Outputs are registered. A request pulse present before clock edge k is reflected on the outputs after edge k, and not before it. `cpu_lvl`, `gie` and the control words are sampled at the same edge.
- R10: A request pulse for the node being acknowledged, in the same cycle as the acknowledge, leaves that node pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_pulse | input | N_NODES | Per-node request pulse |
| ctrl_flat | input | 9*N_NODES | Control words, node i at bits [9i+8:9i] |
| cpu_lvl | input | 4 | Current CPU priority level |
| gie | input | 1 | Global interrupt enable |
| ack | input | 1 | CPU acknowledge of the offered winner |
| win_idx | output | $clog2(N_NODES) | Index of the winning node |
| win_lvl | output | 4 | Level of the winning node |
| take_req | output | 1 | Winner is requested from the CPU |

## Verification
The hardest situations to reach are those where the acknowledge meets something other than a plain offer. One is an acknowledge arriving while the winner is only held. The other is an acknowledge colliding with a fresh request from the same node. Both demand exact cycle alignment of `ack`, `cpu_lvl` and `req_pulse`. The stimulus table builds up a pending set across rows, so that a blocked node survives several acknowledges of other nodes. It then raises the CPU level to equal the winner's level and issues an `ack` there. Directed steps then drive a request pulse on the offered node in the very cycle its `ack` is given.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int CW       = 9;
    localparam int LVL_W    = 4;
    localparam int GRP_W    = 2;
    localparam int SUB_W    = GRP_W + 1;
    localparam int KEY_W    = LVL_W + SUB_W;
    localparam int GRP_LSB  = 0;
    localparam int LVL_LSB  = 2;
    localparam int EN_BIT   = 6;
    localparam int EXT_BIT  = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HELD  = 2'd1,
        ST_OFFER = 2'd2
    } arb_state_t;

    typedef struct packed {
        logic             en;
        logic [LVL_W-1:0] lvl;
        logic [SUB_W-1:0] sub;
    } node_cfg_t;

    function automatic node_cfg_t decode_cw(input logic [CW-1:0] w);
        node_cfg_t c;
        c.en  = w[EN_BIT];
        c.lvl = w[LVL_LSB +: LVL_W];
        c.sub = {w[EXT_BIT], w[GRP_LSB +: GRP_W]};
        return c;
    endfunction
endpackage

// File: rtl/irq_arb_pending.sv
module irq_arb_pending #(
    parameter int N_NODES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_NODES-1:0] set_vec,
    input  logic [N_NODES-1:0] clr_vec,
    output logic [N_NODES-1:0] pend_q,
    output logic [N_NODES-1:0] pend_nxt
);
    // a new pulse outranks a clear of the same node
    assign pend_nxt = (pend_q & ~clr_vec) | set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nxt;
    end

    // R4: a bit set earlier and not cleared is still set
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~$past(clr_vec)) & ~pend_q) == '0));

    // R6: at most one node is cleared per cycle
    p_single_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_vec));
endmodule

// File: rtl/irq_arb_pick.sv
module irq_arb_pick
    import irq_arb_pkg::*;
#(
    parameter int N_NODES = 16,
    localparam int IW     = $clog2(N_NODES)
) (
    input  logic [N_NODES-1:0]    cand,
    input  logic [N_NODES*CW-1:0] ctrl_flat,
    output logic                  found,
    output logic [IW-1:0]         best_idx,
    output logic [LVL_W-1:0]      best_lvl
);
    node_cfg_t          cfg  [N_NODES];
    logic [N_NODES-1:0] elig;

    for (genvar i = 0; i < N_NODES; i++) begin : g_node
        assign cfg[i]  = decode_cw(ctrl_flat[i*CW +: CW]);
        assign elig[i] = cand[i] && cfg[i].en && (cfg[i].lvl != '0);
    end

    logic [KEY_W-1:0] best_key;

    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_lvl = '0;
        best_key = '0;
        for (int i = 0; i < N_NODES; i++) begin
            // strict compare keeps the lower index on a tie
            if (elig[i] && (!found || {cfg[i].lvl, cfg[i].sub} > best_key)) begin
                found    = 1'b1;
                best_idx = IW'(i);
                best_lvl = cfg[i].lvl;
                best_key = {cfg[i].lvl, cfg[i].sub};
            end
        end
    end
endmodule

// File: rtl/irq_sublevel_arbiter.sv
module irq_sublevel_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_NODES = 16,
    localparam int IW     = $clog2(N_NODES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_NODES-1:0]    req_pulse,
    input  logic [N_NODES*CW-1:0] ctrl_flat,
    input  logic [LVL_W-1:0]      cpu_lvl,
    input  logic                  gie,
    input  logic                  ack,
    output logic [IW-1:0]         win_idx,
    output logic [LVL_W-1:0]      win_lvl,
    output logic                  take_req
);
    arb_state_t         state_q, state_d;
    logic [N_NODES-1:0] clr_vec, pend_q, pend_nxt;
    logic               found;
    logic [IW-1:0]      best_idx;
    logic [LVL_W-1:0]   best_lvl;

    always_comb begin
        clr_vec = '0;
        if (ack && state_q == ST_OFFER) clr_vec[win_idx] = 1'b1;
    end

    irq_arb_pending #(.N_NODES(N_NODES)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_vec(req_pulse), .clr_vec(clr_vec),
        .pend_q(pend_q), .pend_nxt(pend_nxt)
    );

    irq_arb_pick #(.N_NODES(N_NODES)) u_pick (
        .cand(pend_nxt), .ctrl_flat(ctrl_flat), .found(found),
        .best_idx(best_idx), .best_lvl(best_lvl)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_HELD, ST_OFFER: begin
                if (!found)                          state_d = ST_IDLE;   // go_idle
                else if (gie && best_lvl > cpu_lvl)  state_d = ST_OFFER;  // go_offer
                else                                 state_d = ST_HELD;   // go_held
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered winner outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_idx <= '0;
            win_lvl <= '0;
        end else if (state_d == ST_IDLE) begin
            win_idx <= '0;
            win_lvl <= '0;
        end else begin
            win_idx <= best_idx;
            win_lvl <= best_lvl;
        end
    end

    assign take_req = (state_q == ST_OFFER);

    // R3: an offer implies enable and strictly higher level at the sampling edge
    p_offer_above_cpu_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |-> ($past(gie) && (win_lvl > $past(cpu_lvl))));

    // R4: a shown winner is pending
    p_winner_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> pend_q[win_idx]);

    // R5: a shown winner never has level 0
    p_winner_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (win_lvl != '0));

    // R6: accepted acknowledge without a new pulse clears that node
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && take_req && !req_pulse[win_idx]) |=> !pend_q[$past(win_idx)]);
endmodule

// File: tb/irq_sublevel_arbiter_test.sv
module irq_sublevel_arbiter_test;
    localparam int N  = 16;
    localparam int CW = 9;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_pulse = '0;
    logic [N*CW-1:0] ctrl_flat = '0;
    logic [3:0]      cpu_lvl = '0;
    logic            gie = 1'b0;
    logic            ack = 1'b0;
    logic [3:0]      win_idx;
    logic [3:0]      win_lvl;
    logic            take_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_sublevel_arbiter #(.N_NODES(N)) uut (
        .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .ctrl_flat(ctrl_flat),
        .cpu_lvl(cpu_lvl), .gie(gie), .ack(ack),
        .win_idx(win_idx), .win_lvl(win_lvl), .take_req(take_req)
    );

    // R2 layout: grp [1:0], lvl [5:2], en [6], spare [7], ext [8]
    function automatic logic [CW-1:0] mk(int lvl, int grp, bit ext, bit en, bit spare);
        logic [CW-1:0] w;
        w = '0;
        w[1:0] = grp[1:0];
        w[5:2] = lvl[3:0];
        w[6]   = en;
        w[7]   = spare;
        w[8]   = ext;
        return w;
    endfunction

    // row: req[30:15] cpu[14:11] gie[10] take[9] idx[8:5] lvl[4:1] ack[0]
    localparam int ROWS = 13;
    localparam logic [30:0] TBL [ROWS] = '{
        {16'h0012, 4'd0,  1'b1, 1'b1, 4'd1, 4'd13, 1'b1},
        {16'h0000, 4'd0,  1'b1, 1'b1, 4'd4, 4'd13, 1'b1},
        {16'h0022, 4'd0,  1'b1, 1'b1, 4'd5, 4'd13, 1'b1},
        {16'h0300, 4'd0,  1'b1, 1'b1, 4'd1, 4'd13, 1'b0},
        {16'h0008, 4'd15, 1'b1, 1'b0, 4'd3, 4'd15, 1'b1},
        {16'h0000, 4'd14, 1'b1, 1'b1, 4'd3, 4'd15, 1'b1},
        {16'h0004, 4'd14, 1'b1, 1'b0, 4'd2, 4'd14, 1'b0},
        {16'h0000, 4'd13, 1'b0, 1'b0, 4'd2, 4'd14, 1'b0},
        {16'h0000, 4'd13, 1'b1, 1'b1, 4'd2, 4'd14, 1'b1},
        {16'h0000, 4'd12, 1'b1, 1'b1, 4'd1, 4'd13, 1'b1},
        {16'h0000, 4'd0,  1'b1, 1'b1, 4'd9, 4'd9,  1'b1},
        {16'h0000, 4'd0,  1'b1, 1'b1, 4'd8, 4'd9,  1'b1},
        {16'h00C0, 4'd0,  1'b1, 1'b0, 4'd0, 4'd0,  1'b0}
    };
    localparam string TAG [ROWS] = '{
        "R8 tie lower index", "R6 ack clears only winner", "R7 sublevel ext over group",
        "R4 earlier pending kept", "R3 equal level held", "R6 ack in held ignored",
        "R3 equal level held", "R3 gie off held", "R3 offer above cpu",
        "R7 level order", "R2 spare bit ignored / R7 group", "R8 last pending",
        "R5 level 0 and disabled never win"
    };

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_out(string tag, bit t, int idx, int lvl);
        chk({tag, " take_req"}, int'(take_req), int'(t));
        chk({tag, " win_idx"}, int'(win_idx), idx);
        chk({tag, " win_lvl"}, int'(win_lvl), lvl);
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(posedge clk); @(negedge clk);
        ack = 1'b0;
    endtask

    initial begin
        ctrl_flat[0*CW +: CW] = mk(12, 0, 0, 1, 0);
        ctrl_flat[1*CW +: CW] = mk(13, 1, 0, 1, 0);
        ctrl_flat[2*CW +: CW] = mk(14, 2, 1, 1, 0);
        ctrl_flat[3*CW +: CW] = mk(15, 3, 1, 1, 0);
        ctrl_flat[4*CW +: CW] = mk(13, 1, 0, 1, 0);
        ctrl_flat[5*CW +: CW] = mk(13, 0, 1, 1, 0);
        ctrl_flat[6*CW +: CW] = mk(15, 3, 0, 0, 0);
        ctrl_flat[7*CW +: CW] = mk(0,  3, 0, 1, 0);
        ctrl_flat[8*CW +: CW] = mk(9,  0, 0, 1, 0);
        ctrl_flat[9*CW +: CW] = mk(9,  3, 0, 1, 1);

        repeat (3) @(negedge clk);
        chk_out("R1 in reset", 1'b0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_out("R1 after reset", 1'b0, 0, 0);

        for (int r = 0; r < ROWS; r++) begin
            req_pulse = TBL[r][30:15];
            cpu_lvl   = TBL[r][14:11];
            gie       = TBL[r][10];
            @(posedge clk); @(negedge clk);
            req_pulse = '0;
            chk_out(TAG[r], TBL[r][9], int'(TBL[r][8:5]), int'(TBL[r][4:1]));
            if (TBL[r][0]) pulse_ack();
        end

        // R2: disabled node 6 is still pending and wins once enabled
        cpu_lvl = 4'd0; gie = 1'b1;
        ctrl_flat[6*CW +: CW] = mk(15, 0, 0, 1, 0);
        @(posedge clk); @(negedge clk);
        chk_out("R2 enabled later wins", 1'b1, 6, 15);
        pulse_ack();
        // R5: node 7 pending with level 0 stays out
        chk_out("R5 level 0 remains out", 1'b0, 0, 0);

        // R10: same-node pulse during ack keeps it pending
        req_pulse[3] = 1'b1;
        @(posedge clk); @(negedge clk);
        req_pulse = '0;
        chk_out("R10 setup offer", 1'b1, 3, 15);
        ack = 1'b1; req_pulse[3] = 1'b1;
        @(posedge clk); @(negedge clk);
        ack = 1'b0; req_pulse = '0;
        chk_out("R10 still pending", 1'b1, 3, 15);
        pulse_ack();
        chk_out("R6 cleared after plain ack", 1'b0, 0, 0);

        // R9: nothing visible before the sampling edge
        req_pulse[2] = 1'b1;
        #1;
        chk("R9 before edge take_req", int'(take_req), 0);
        @(posedge clk); @(negedge clk);
        req_pulse = '0;
        chk_out("R9 after edge", 1'b1, 2, 14);

        // R1: reset empties pending
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_out("R1 reset clears pending", 1'b0, 0, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule